// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block holds an up/down counter with a clock prescaler and lets an external trigger control it. One of several trigger lines is picked by a select field. The picked line passes through a two-flop synchronizer and then an edge detector. The synchronized trigger then acts on the counter according to a two-bit slave mode, with these encodings:

- 0 = off
- 1 = restart
- 2 = pause
- 3 = trigger

The block also owns the shadow/active pairs for the reload value and the prescaler divisor. An update event copies the preload inputs into the active copies. An update event comes from one of three causes: a software update request, a counter wrap, or a restart trigger edge. The last two are suppressed while the update-disable input is high. A restart always reinitializes the counter and prescaler, whether or not an update event goes with it.

The counter is gated by a run-state machine with two states, STOP and RUN:

- STOP to RUN: a software enable pulse, or, in trigger mode, a detected trigger rising edge.
- RUN to STOP: a software disable pulse only. The disable pulse wins over any start in the same cycle.

The block keeps a sticky trigger-event flag and a self-clearing update-generation bit.

Top module: `tmr_slave_ctl`

## Requirements
- R1: After reset the following outputs read zero: `cnt_val`, `cnt_en`, `tef`, `ug_bit`, `upd_evt` and `psc_act`. `reload_act` reads all ones.
- R2: Only the trigger line indexed by `trig_sel` has any effect. Edges on the other lines change neither `tef` nor `cnt_val`.
- R3: Suppose the selected trigger line changes before clock edge k. Then any counter, flag or enable action it causes becomes visible just after edge k+2, and not before.
- R4: In restart mode (`mode_sel`=1), a trigger rising edge reinitializes the prescaler and the counter. The counter goes to 0 when counting up. In modes 0, 2 and 3 an edge never reinitializes the counter.
- R5: With `upd_dis`=1, a restart edge produces no update event. `reload_act` and `psc_act` stay unchanged, and the counter is still reinitialized.
- R6: With `upd_dis`=0, a restart edge pulses `upd_evt` for one cycle and loads `reload_pre` and `psc_pre` into the active copies. A down-counter restarts at the new reload value. A software `ug_set` pulse does the same regardless of `upd_dis`.
- R7: `ug_bit` is high for exactly the cycle after a software `ug_set` or a restart-mode trigger edge.
- R8: `tef` is set by a trigger rising edge in modes 1, 2 and 3. It holds until `tef_clr` is 1, and a set wins over a clear in the same cycle. In mode 0, edges leave `tef` at 0.
- R9: In pause mode (`mode_sel`=2), the counter and prescaler advance only while the synchronized trigger is high, and hold while it is low.
- R10: In trigger mode (`mode_sel`=3), a rising edge moves the run state from STOP to RUN. Later edges neither stop nor reset the count.
- R11: An up-counter with prescaler divisor 0 steps once per clock from 0 to `reload_act`, then wraps to 0. When `upd_dis`=0, the wrap pulses `upd_evt`.
- R12: An `en_set` pulse raises `cnt_en` on the next edge. An `en_clr` pulse drops it, and after that the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_src | input | NSRC | Candidate trigger lines |
| trig_sel | input | SEL_W | Index of the trigger line in use |
| mode_sel | input | 2 | Slave mode: 0 off, 1 restart, 2 pause, 3 trigger |
| upd_dis | input | 1 | Suppresses hardware update events |
| dir_down | input | 1 | 1 = count down, 0 = count up |
| reload_pre | input | CNT_W | Preload reload value |
| psc_pre | input | PSC_W | Preload prescaler divisor minus one |
| en_set | input | 1 | Software counter-enable pulse |
| en_clr | input | 1 | Software counter-disable pulse |
| ug_set | input | 1 | Software update request pulse |
| tef_clr | input | 1 | Write-one-to-clear of the trigger-event flag |
| cnt_val | output | CNT_W | Counter value |
| reload_act | output | CNT_W | Active reload value |
| psc_act | output | PSC_W | Active prescaler divisor |
| cnt_en | output | 1 | Run state is RUN |
| tef | output | 1 | Sticky trigger-event flag |
| ug_bit | output | 1 | Update-generation bit |
| upd_evt | output | 1 | One-cycle update event |

## Verification
The bench targets the split between reinitialization and update. It restarts once with updates disabled and checks that the active reload and prescaler stay at their old values while the counter still returns to zero. It then restarts a down-counter with updates enabled and checks that the counter reloads to the new value and that the prescaler restarts its division; a design that used the stale reload, or kept the old prescaler phase, shows a wrong count three cycles later.

Several other corner cases are covered:
- Set and clear of the flag in the same cycle. A design that let the clear win would leave the flag low.
- The exact third-edge latency of the synchronizer. A design with a missing or extra flop would act one cycle early or late.
- A second edge in trigger mode. A design that restarted on it would show a count of 0 instead of 8.
- Edges on an unselected line, and edges in mode 0. A design that reacted to either would set the flag.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

    typedef enum logic [1:0] {
        SM_OFF     = 2'd0,
        SM_RESTART = 2'd1,
        SM_PAUSE   = 2'd2,
        SM_TRIGGER = 2'd3
    } slave_mode_e;

    typedef enum logic {
        RS_STOP = 1'b0,
        RS_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
    parameter int NSRC  = 4,
    parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src,
    input  logic [SEL_W-1:0] sel,
    output logic             lvl,
    output logic             rise
);
    localparam int STAGES = 3;

    logic [STAGES-1:0] chain_q;
    logic              picked;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) picked = src[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], picked};
    end

    assign lvl  = chain_q[1];
    assign rise = chain_q[1] & ~chain_q[2];

endmodule

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_slave_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  slave_mode_e mode,
    input  logic        trig_rise,
    input  logic        trig_lvl,
    input  logic        en_set,
    input  logic        en_clr,
    output logic        go,
    output logic        run_en
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_STOP: if (!en_clr && (en_set || (mode == SM_TRIGGER && trig_rise)))
                         state_d = RS_RUN;
            RS_RUN:  if (en_clr) state_d = RS_STOP;
            default: state_d = RS_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        run_en = 1'b0;
        go     = 1'b0;
        unique case (state_q)
            RS_STOP: begin
                run_en = 1'b0;
                go     = 1'b0;
            end
            RS_RUN: begin
                run_en = 1'b1;
                go     = (mode != SM_PAUSE) || trig_lvl;
            end
            default: ;
        endcase
    end

    AST_TRIG_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_RUN && !en_clr) |=> (state_q == RS_RUN)); // R10

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
    parameter int              CNT_W      = 16,
    parameter int              PSC_W      = 8,
    parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             restart_hit,
    input  logic             sw_ug,
    input  logic             upd_dis,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] reload_pre,
    input  logic [PSC_W-1:0] psc_pre,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload_act,
    output logic [PSC_W-1:0] psc_act,
    output logic             upd_evt
);
    logic [CNT_W-1:0] cnt_q, rld_q;
    logic [PSC_W-1:0] pdiv_q, pcnt_q;
    logic             upd_q;
    logic             reinit, psc_tick, at_end, wrap, upd_now;
    logic [CNT_W-1:0] reload_src;

    assign reinit     = sw_ug | restart_hit;
    assign psc_tick   = go && (pcnt_q >= pdiv_q);
    assign at_end     = dir_down ? (cnt_q == '0) : (cnt_q >= rld_q);
    assign wrap       = psc_tick && at_end && !reinit;
    assign upd_now    = sw_ug | (!upd_dis & (restart_hit | wrap));
    assign reload_src = upd_now ? reload_pre : rld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rld_q  <= RELOAD_RST;
            pdiv_q <= '0;
            pcnt_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= upd_now;
            if (upd_now) begin
                rld_q  <= reload_pre;
                pdiv_q <= psc_pre;
            end
            if (reinit)        pcnt_q <= '0;
            else if (psc_tick) pcnt_q <= '0;
            else if (go)       pcnt_q <= pcnt_q + 1'b1;
            if (reinit) begin
                cnt_q <= dir_down ? reload_src : '0;
            end else if (psc_tick) begin
                if (at_end)        cnt_q <= dir_down ? reload_src : '0;
                else if (dir_down) cnt_q <= cnt_q - 1'b1;
                else               cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt        = cnt_q;
    assign reload_act = rld_q;
    assign psc_act    = pdiv_q;
    assign upd_evt    = upd_q;

    AST_REINIT_UP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit && !dir_down) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
    import tmr_slave_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  trig_src,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic [1:0]       mode_sel,
    input  logic             upd_dis,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] reload_pre,
    input  logic [PSC_W-1:0] psc_pre,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             ug_set,
    input  logic             tef_clr,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] reload_act,
    output logic [PSC_W-1:0] psc_act,
    output logic             cnt_en,
    output logic             tef,
    output logic             ug_bit,
    output logic             upd_evt
);
    slave_mode_e mode;
    logic        trig_lvl, trig_rise, hw_edge, restart_hit, go;
    logic        tef_q, ug_q;

    assign mode        = slave_mode_e'(mode_sel);
    assign hw_edge     = trig_rise && (mode != SM_OFF);
    assign restart_hit = hw_edge && (mode == SM_RESTART);

    tmr_trig_sync #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (trig_src),
        .sel  (trig_sel),
        .lvl  (trig_lvl),
        .rise (trig_rise)
    );

    tmr_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .trig_rise(trig_rise),
        .trig_lvl (trig_lvl),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .go       (go),
        .run_en   (cnt_en)
    );

    tmr_cnt_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .restart_hit(restart_hit),
        .sw_ug      (ug_set),
        .upd_dis    (upd_dis),
        .dir_down   (dir_down),
        .reload_pre (reload_pre),
        .psc_pre    (psc_pre),
        .cnt        (cnt_val),
        .reload_act (reload_act),
        .psc_act    (psc_act),
        .upd_evt    (upd_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tef_q <= 1'b0;
            ug_q  <= 1'b0;
        end else begin
            ug_q <= ug_set | restart_hit;
            if (hw_edge)      tef_q <= 1'b1;
            else if (tef_clr) tef_q <= 1'b0;
        end
    end

    assign tef    = tef_q;
    assign ug_bit = ug_q;

    AST_NO_UPD_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_hit && upd_dis && !ug_set) |=> !upd_evt); // R5
    AST_TEF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tef && !tef_clr) |=> tef); // R8
    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_PAUSE && !trig_lvl && !ug_set) |=> $stable(cnt_val)); // R9
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !ug_set && !restart_hit) |=> $stable(cnt_val)); // R12
    AST_UG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ug_bit && !ug_set && !restart_hit) |=> !ug_bit); // R7

endmodule

// File: tb/tmr_slave_ctl_bench.sv
module tmr_slave_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 4;
    localparam int SEL_W = 2;
    localparam int CNT_W = 16;
    localparam int PSC_W = 8;

    typedef enum int {F_CNT, F_EN, F_TEF, F_UG, F_UPD, F_RLD, F_PSC} fld_e;
    typedef struct {
        string       req;
        fld_e        fld;
        int unsigned exp;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  trig_src = '0;
    logic [SEL_W-1:0] trig_sel = '0;
    logic [1:0]       mode_sel = '0;
    logic             upd_dis = 1'b0, dir_down = 1'b0;
    logic [CNT_W-1:0] reload_pre = '0;
    logic [PSC_W-1:0] psc_pre = '0;
    logic             en_set = 1'b0, en_clr = 1'b0, ug_set = 1'b0, tef_clr = 1'b0;
    logic [CNT_W-1:0] cnt_val, reload_act;
    logic [PSC_W-1:0] psc_act;
    logic             cnt_en, tef, ug_bit, upd_evt;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_slave_ctl #(.NSRC(NSRC), .SEL_W(SEL_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_tmr_slave_ctl (
        .clk(clk), .rst_n(rst_n), .trig_src(trig_src), .trig_sel(trig_sel),
        .mode_sel(mode_sel), .upd_dis(upd_dis), .dir_down(dir_down),
        .reload_pre(reload_pre), .psc_pre(psc_pre), .en_set(en_set), .en_clr(en_clr),
        .ug_set(ug_set), .tef_clr(tef_clr), .cnt_val(cnt_val), .reload_act(reload_act),
        .psc_act(psc_act), .cnt_en(cnt_en), .tef(tef), .ug_bit(ug_bit), .upd_evt(upd_evt)
    );

    function automatic int unsigned actual(fld_e f);
        case (f)
            F_CNT:   return int'(cnt_val);
            F_EN:    return int'(cnt_en);
            F_TEF:   return int'(tef);
            F_UG:    return int'(ug_bit);
            F_UPD:   return int'(upd_evt);
            F_RLD:   return int'(reload_act);
            default: return int'(psc_act);
        endcase
    endfunction

    // monitor: pops expectations half a period after the edge they describe
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            int unsigned act;
            it  = sb_q.pop_front();
            act = actual(it.fld);
            n_vec++;
            if (act != it.exp) begin
                n_bad++;
                $display("FAIL %s field=%s actual=%0d expected=%0d", it.req, it.fld.name(), act, it.exp);
            end
        end
    end

    task automatic chk(input string r, input fld_e f, input int unsigned v);
        item_t it;
        it.req = r; it.fld = f; it.exp = v;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic tickn(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state, R1
        tickn(2);
        chk("R1", F_CNT, 0); chk("R1", F_EN, 0); chk("R1", F_TEF, 0);
        chk("R1", F_UG, 0); chk("R1", F_UPD, 0); chk("R1", F_RLD, 16'hFFFF); chk("R1", F_PSC, 0);
        rst_n = 1'b1;
        tick();

        // software update, R6 / R7
        reload_pre = 10; ug_set = 1'b1;
        tick(); ug_set = 1'b0;
        chk("R7", F_UG, 1); chk("R6", F_UPD, 1); chk("R6", F_RLD, 10); chk("R4", F_CNT, 0);
        tick();
        chk("R7", F_UG, 0); chk("R6", F_UPD, 0);

        // software enable and wrap, R12 / R11
        en_set = 1'b1;
        tick(); en_set = 1'b0;
        chk("R12", F_EN, 1); chk("R12", F_CNT, 0);
        for (int i = 1; i <= 10; i++) begin
            tick(); chk("R11", F_CNT, i);
        end
        tick();
        chk("R11", F_CNT, 0); chk("R11", F_UPD, 1); chk("R7", F_UG, 0);

        // restart with update disabled, R3 / R4 / R5
        mode_sel = 2'd1; trig_sel = 2'd1; upd_dis = 1'b1;
        reload_pre = 20; psc_pre = 2; trig_src[1] = 1'b1;
        tick(); chk("R3", F_CNT, 1);
        tick(); chk("R3", F_CNT, 2); chk("R3", F_TEF, 0);
        tick();
        chk("R4", F_CNT, 0); chk("R8", F_TEF, 1); chk("R7", F_UG, 1);
        chk("R5", F_UPD, 0); chk("R5", F_RLD, 10); chk("R5", F_PSC, 0);
        tick(); chk("R4", F_CNT, 1); chk("R7", F_UG, 0);

        // flag clear, and set beating clear, R8
        tef_clr = 1'b1;
        tick(); tef_clr = 1'b0;
        chk("R8", F_TEF, 0);
        trig_src[1] = 1'b0; tickn(3);
        trig_src[1] = 1'b1; tick(); tick();
        tef_clr = 1'b1;
        tick(); tef_clr = 1'b0;
        chk("R8", F_TEF, 1); chk("R4", F_CNT, 0);

        // restart with update, down-counting, R6
        trig_src[1] = 1'b0; tickn(3);
        dir_down = 1'b1; upd_dis = 1'b0; trig_src[1] = 1'b1;
        tick(); tick(); chk("R3", F_UG, 0);
        tick();
        chk("R6", F_CNT, 20); chk("R6", F_UPD, 1); chk("R6", F_RLD, 20); chk("R6", F_PSC, 2); chk("R7", F_UG, 1);
        tick(); chk("R6", F_CNT, 20); chk("R6", F_UPD, 0);
        tick(); chk("R6", F_CNT, 20);
        tick(); chk("R6", F_CNT, 19);

        // pause mode, R9
        tef_clr = 1'b1;
        tick(); tef_clr = 1'b0;
        mode_sel = 2'd2; dir_down = 1'b0; psc_pre = 0; trig_src[1] = 1'b0;
        tickn(3);
        ug_set = 1'b1;
        tick(); ug_set = 1'b0;
        chk("R7", F_UG, 1); chk("R9", F_CNT, 0); chk("R6", F_PSC, 0);
        tick(); chk("R9", F_CNT, 0);
        tick(); chk("R9", F_CNT, 0);
        trig_src[1] = 1'b1;
        tick(); chk("R9", F_CNT, 0);
        tick(); chk("R3", F_CNT, 0);
        tick(); chk("R9", F_CNT, 1); chk("R8", F_TEF, 1); chk("R7", F_UG, 0);
        tick(); chk("R9", F_CNT, 2);
        trig_src[1] = 1'b0;
        tick(); chk("R9", F_CNT, 3);
        tick(); chk("R9", F_CNT, 4);
        tick(); chk("R9", F_CNT, 4);
        tick(); chk("R9", F_CNT, 4);

        // trigger mode, R10
        en_clr = 1'b1;
        tick(); en_clr = 1'b0;
        chk("R12", F_EN, 0);
        mode_sel = 2'd3; tef_clr = 1'b1; ug_set = 1'b1;
        tick(); tef_clr = 1'b0; ug_set = 1'b0;
        chk("R10", F_CNT, 0); chk("R8", F_TEF, 0);
        tick(); chk("R10", F_EN, 0); chk("R10", F_CNT, 0);
        tick(); chk("R10", F_CNT, 0);
        trig_src[1] = 1'b1;
        tick(); chk("R10", F_EN, 0);
        tick(); chk("R3", F_EN, 0);
        tick(); chk("R10", F_EN, 1); chk("R10", F_CNT, 0); chk("R8", F_TEF, 1);
        tick(); chk("R10", F_CNT, 1);
        tick(); chk("R10", F_CNT, 2);
        trig_src[1] = 1'b0;
        tickn(3); chk("R10", F_CNT, 5);
        trig_src[1] = 1'b1;
        tickn(3); chk("R10", F_CNT, 8); chk("R10", F_EN, 1);

        // source select, R2
        mode_sel = 2'd1; tef_clr = 1'b1;
        tick(); tef_clr = 1'b0;
        chk("R8", F_TEF, 0); chk("R2", F_CNT, 9);
        trig_src[0] = 1'b1;
        tickn(3); chk("R2", F_CNT, 12); chk("R2", F_TEF, 0); chk("R2", F_UG, 0);
        trig_sel = 2'd0; trig_src[0] = 1'b0;
        tickn(3); chk("R2", F_CNT, 15);
        trig_src[0] = 1'b1;
        tickn(2); chk("R2", F_CNT, 17);
        tick(); chk("R2", F_CNT, 0); chk("R2", F_TEF, 1);

        // mode off ignores edges, R8 / R4
        mode_sel = 2'd0; tef_clr = 1'b1;
        tick(); tef_clr = 1'b0;
        chk("R8", F_TEF, 0); chk("R4", F_CNT, 1);
        trig_src[0] = 1'b0; tickn(3);
        trig_src[0] = 1'b1; tickn(3);
        chk("R8", F_TEF, 0); chk("R4", F_CNT, 7); chk("R7", F_UG, 0);

        // software stop, R12
        en_clr = 1'b1;
        tick(); en_clr = 1'b0;
        chk("R12", F_EN, 0); chk("R12", F_CNT, 8);
        tick(); chk("R12", F_CNT, 8);
        tick(); chk("R12", F_CNT, 8);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule